// File: doc/BRIEF.md
# Edge/Level Interrupt Request Latch

This block turns eight asynchronous interrupt lines into a vector of pending requests. Every line is first brought into the clock domain through a two-stage synchronizer. A separate register keeps the previous synchronized level of each line, and the block uses it to find rising edges. Each channel follows its own trigger rule. An edge channel latches a request on a low-to-high transition, and the request stays pending until it is acknowledged. A level channel's request follows the synchronized input.

Software chooses the rule per channel through a trigger-select register. Each instance carries a fixed mask parameter, and only the channels whose mask bit is set can ever be switched to level mode. The other channels always read back as edge channels. A downstream controller clears one pending request through the acknowledge port. An initialization strobe clears the request, previous-level and trigger-select state. The raw request vector is the block's only result, and priority resolution is left to the logic that consumes it.

Top module: `irq_trigger_latch`

## Requirements
- R1: After reset `req_o` is 0 and `cfg_rdata_o` is 0, so every channel starts in edge mode.
- R2: A change on `irq_i[n]` passes through two synchronizer flops and then the request register. A rise on the input before clock edge k therefore shows on `req_o[n]` after edge k+2.
- R3: In edge mode (trigger bit n = 0), `req_o[n]` is set when the synchronized input is 1 and its previous level is 0. A later fall of the input leaves `req_o[n]` set.
- R4: In level mode (trigger bit n = 1), `req_o[n]` equals the synchronized input of the previous cycle. It is set while the input is high and cleared when the input is low.
- R5: A write (`cfg_we_i` = 1) stores `cfg_wdata_i & WR_MASK` into the trigger-select register. Bit positions where `WR_MASK` is 0 always hold 0. The masks used are 8'hF8 and 8'hDE.
- R6: `cfg_rdata_o` always shows the stored trigger-select value, one cycle after the write edge.
- R7: In edge mode, `ack_valid_i` = 1 with `ack_idx_i` = n, given as a binary channel number, clears `req_o[n]` at the next edge. Other channels are not affected.
- R8: An acknowledge of a level-mode channel whose synchronized input is high leaves `req_o[n]` set.
- R9: If an acknowledge of edge channel n lands in the same cycle as a newly detected rising edge on n, the edge wins and `req_o[n]` stays set.
- R10: `init_i` clears the request, previous-level and trigger-select registers at the next edge. It takes priority over a trigger-select write in the same cycle.
- R11: An edge channel whose input stays high after an acknowledge does not set its request again until the input falls and rises once more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_i | input | NCH | Asynchronous interrupt lines |
| init_i | input | 1 | Clears request, previous-level and trigger state |
| ack_valid_i | input | 1 | Acknowledge strobe |
| ack_idx_i | input | IDX_W | Binary number of the acknowledged channel |
| cfg_we_i | input | 1 | Trigger-select write enable |
| cfg_wdata_i | input | NCH | Trigger-select write value (1 = level) |
| cfg_rdata_o | output | NCH | Stored trigger-select value |
| req_o | output | NCH | Pending request vector |

## Verification
The assertions check several rules on every cycle: bits outside the write mask never read 1, an initialization empties all state, level channels copy the synchronized input, pending edge requests hold without an acknowledge, and an acknowledge with no competing edge clears its bit. The bench scenarios are needed to show the synchronizer latency measured from the pins and the outcome when an acknowledge and a fresh edge collide. They also show that a held input does not trigger a second time after an acknowledge, and they check the readback for two instances with different masks.

// File: rtl/irq_latch_pkg.sv
package irq_latch_pkg;
    localparam logic [7:0] MASK_PRIMARY   = 8'hF8;
    localparam logic [7:0] MASK_SECONDARY = 8'hDE;

    typedef enum logic {
        TRIG_EDGE  = 1'b0,
        TRIG_LEVEL = 1'b1
    } trig_mode_e;
endpackage

// File: rtl/irq_sync_chain.sv
module irq_sync_chain #(
    parameter int NCH    = 8,
    parameter int STAGES = 2
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [NCH-1:0] async_i,
    output logic [NCH-1:0] sync_o
);
    logic [NCH-1:0] stage_q [STAGES];
    logic [NCH-1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_trig_cfg.sv
module irq_trig_cfg #(
    parameter int             NCH     = 8,
    parameter logic [NCH-1:0] WR_MASK = '1
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           init_i,
    input  logic           we_i,
    input  logic [NCH-1:0] wdata_i,
    output logic [NCH-1:0] trig_o
);
    logic [NCH-1:0] trig_d, trig_q;

    always_comb begin
        trig_d = trig_q;
        if (init_i)    trig_d = '0;
        else if (we_i) trig_d = wdata_i & WR_MASK;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) trig_q <= '0;
        else         trig_q <= trig_d;
    end

    assign trig_o = trig_q;
endmodule

// File: rtl/irq_req_core.sv
module irq_req_core
    import irq_latch_pkg::*;
#(
    parameter int NCH   = 8,
    parameter int IDX_W = $clog2(NCH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             init_i,
    input  logic [NCH-1:0]   lvl_i,
    input  logic [NCH-1:0]   trig_i,
    input  logic             ack_valid_i,
    input  logic [IDX_W-1:0] ack_idx_i,
    output logic [NCH-1:0]   req_o,
    output logic [NCH-1:0]   last_o
);
    typedef struct packed {
        logic [NCH-1:0] req;
        logic [NCH-1:0] last;
    } core_state_t;

    core_state_t st_d, st_q;
    logic [NCH-1:0] ack_hit;
    logic [NCH-1:0] rise;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_chan
            assign ack_hit[c] = ack_valid_i && (ack_idx_i == IDX_W'(c));
            assign rise[c]    = lvl_i[c] & ~st_q.last[c];
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        for (int c = 0; c < NCH; c++) begin
            st_d.last[c] = lvl_i[c];
            if (trig_mode_e'(trig_i[c]) == TRIG_LEVEL) begin
                st_d.req[c] = lvl_i[c];
            end else begin
                st_d.req[c] = rise[c] | (st_q.req[c] & ~ack_hit[c]);
            end
        end
        if (init_i) begin
            st_d = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign req_o  = st_q.req;
    assign last_o = st_q.last;
endmodule

// File: rtl/irq_trigger_latch.sv
module irq_trigger_latch
    import irq_latch_pkg::*;
#(
    parameter int             NCH         = 8,
    parameter int             SYNC_STAGES = 2,
    parameter logic [NCH-1:0] WR_MASK     = MASK_PRIMARY,
    localparam int            IDX_W       = $clog2(NCH)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NCH-1:0]   irq_i,
    input  logic             init_i,
    input  logic             ack_valid_i,
    input  logic [IDX_W-1:0] ack_idx_i,
    input  logic             cfg_we_i,
    input  logic [NCH-1:0]   cfg_wdata_i,
    output logic [NCH-1:0]   cfg_rdata_o,
    output logic [NCH-1:0]   req_o
);
    logic [NCH-1:0] sync_lvl;
    logic [NCH-1:0] trig_sel;
    logic [NCH-1:0] last_lvl;

    irq_sync_chain #(.NCH(NCH), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(irq_i),
        .sync_o (sync_lvl)
    );

    irq_trig_cfg #(.NCH(NCH), .WR_MASK(WR_MASK)) u_cfg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .init_i (init_i),
        .we_i   (cfg_we_i),
        .wdata_i(cfg_wdata_i),
        .trig_o (trig_sel)
    );

    irq_req_core #(.NCH(NCH), .IDX_W(IDX_W)) u_core (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .init_i     (init_i),
        .lvl_i      (sync_lvl),
        .trig_i     (trig_sel),
        .ack_valid_i(ack_valid_i),
        .ack_idx_i  (ack_idx_i),
        .req_o      (req_o),
        .last_o     (last_lvl)
    );

    assign cfg_rdata_o = trig_sel;
endmodule

// File: rtl/irq_trigger_latch_chk.sv
module irq_trigger_latch_chk #(
    parameter int             NCH     = 8,
    parameter logic [NCH-1:0] WR_MASK = '1,
    parameter int             IDX_W   = 3
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             init_i,
    input logic             ack_valid_i,
    input logic [IDX_W-1:0] ack_idx_i,
    input logic [NCH-1:0]   cfg_rdata_o,
    input logic [NCH-1:0]   req_o,
    input logic [NCH-1:0]   sync_lvl,
    input logic [NCH-1:0]   last_lvl
);
    logic [NCH-1:0] rise_now;
    assign rise_now = sync_lvl & ~last_lvl;

    AST_FIXED_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_rdata_o & ~WR_MASK) == '0); // R5

    AST_INIT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        init_i |=> (req_o == '0) && (cfg_rdata_o == '0) && (last_lvl == '0)); // R10

    AST_LEVEL_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !init_i |=> ((req_o & $past(cfg_rdata_o)) == ($past(sync_lvl) & $past(cfg_rdata_o)))); // R4

    AST_EDGE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!init_i && !ack_valid_i) |=>
        ((req_o & $past(req_o & ~cfg_rdata_o)) == $past(req_o & ~cfg_rdata_o))); // R3

    AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !init_i |=> ((req_o & $past(rise_now)) == $past(rise_now))); // R9

    AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ack_valid_i && !init_i && !cfg_rdata_o[ack_idx_i] && !rise_now[ack_idx_i])
        |=> !req_o[$past(ack_idx_i)]); // R7
endmodule

bind irq_trigger_latch irq_trigger_latch_chk #(
    .NCH(NCH), .WR_MASK(WR_MASK), .IDX_W(IDX_W)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (init_i),
    .ack_valid_i(ack_valid_i),
    .ack_idx_i  (ack_idx_i),
    .cfg_rdata_o(cfg_rdata_o),
    .req_o      (req_o),
    .sync_lvl   (sync_lvl),
    .last_lvl   (last_lvl)
);

// File: tb/irq_trigger_latch_tb.sv
`timescale 1ns/1ps
module irq_trigger_latch_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq = '0;
    logic       init = 1'b0;
    logic       ack_v = 1'b0;
    logic [2:0] ack_idx = '0;
    logic       cfg_we = 1'b0;
    logic [7:0] cfg_wd = '0;
    logic [7:0] cfg_rd, req;
    logic       sec_we = 1'b0;
    logic [7:0] sec_rd, sec_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_trigger_latch #(.WR_MASK(8'hF8)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .init_i(init),
        .ack_valid_i(ack_v), .ack_idx_i(ack_idx), .cfg_we_i(cfg_we),
        .cfg_wdata_i(cfg_wd), .cfg_rdata_o(cfg_rd), .req_o(req)
    );

    irq_trigger_latch #(.WR_MASK(8'hDE)) dut_sec_i (
        .clk_i(clk), .rst_ni(rst_n), .irq_i(8'h00), .init_i(1'b0),
        .ack_valid_i(1'b0), .ack_idx_i(3'd0), .cfg_we_i(sec_we),
        .cfg_wdata_i(8'hFF), .cfg_rdata_o(sec_rd), .req_o(sec_req)
    );

    // {irq[19:12], ack[11], idx[10:8], expected req[7:0]}, trigger = 8'h08
    localparam logic [19:0] VEC [12] = '{
        {8'h00, 1'b0, 3'd0, 8'h00},
        {8'h01, 1'b0, 3'd0, 8'h01},
        {8'h00, 1'b0, 3'd0, 8'h01},
        {8'h08, 1'b0, 3'd0, 8'h09},
        {8'h00, 1'b0, 3'd0, 8'h01},
        {8'h00, 1'b1, 3'd0, 8'h00},
        {8'h82, 1'b0, 3'd0, 8'h82},
        {8'h82, 1'b1, 3'd7, 8'h02},
        {8'h8A, 1'b1, 3'd3, 8'h0A},
        {8'h00, 1'b1, 3'd1, 8'h00},
        {8'h80, 1'b0, 3'd0, 8'h80},
        {8'h00, 1'b1, 3'd7, 8'h00}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk); cfg_we = 1'b1; cfg_wd = v;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset req", req, 8'h00);
        check("R1 reset trig", cfg_rd, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 / R6: masked write and readback on both instances
        write_cfg(8'h0F);
        check("R5 masked write", cfg_rd, 8'h08);
        @(negedge clk); sec_we = 1'b1;
        @(negedge clk); sec_we = 1'b0;
        check("R5 secondary mask", sec_rd, 8'hDE);
        @(negedge clk);
        check("R6 readback stable", cfg_rd, 8'h08);

        // R3 R4 R7 R8 R11: vector table
        for (int k = 0; k < 12; k++) begin
            logic [19:0] v;
            v = VEC[k];
            irq = v[19:12];
            repeat (3) @(posedge clk);
            @(negedge clk);
            if (v[11]) begin
                ack_v = 1'b1; ack_idx = v[10:8];
                @(negedge clk);
                ack_v = 1'b0;
            end
            check($sformatf("R3/R4/R7/R8/R11 vector %0d", k), req, v[7:0]);
        end

        // R2: latency of two sync stages plus request register
        @(negedge clk); irq = 8'h10;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R2 not yet visible", req, 8'h00);
        @(posedge clk); @(negedge clk);
        check("R2 visible after third edge", req, 8'h10);
        irq = 8'h00;
        repeat (3) @(negedge clk);

        // R9: ack and fresh edge in the same cycle on channel 4 (pending)
        irq = 8'h10;
        @(posedge clk); @(posedge clk); @(negedge clk);
        ack_v = 1'b1; ack_idx = 3'd4;
        @(negedge clk); ack_v = 1'b0;
        check("R9 edge wins over ack", req, 8'h10);
        @(negedge clk); ack_v = 1'b1;
        @(negedge clk); ack_v = 1'b0;
        check("R7 later ack clears", req, 8'h00);
        irq = 8'h00;
        repeat (3) @(negedge clk);

        // R10: init clears state and beats a simultaneous write
        irq = 8'h01;
        repeat (4) @(negedge clk);
        irq = 8'h00;
        repeat (3) @(negedge clk);
        check("R10 pending before init", req, 8'h01);
        init = 1'b1; cfg_we = 1'b1; cfg_wd = 8'hFF;
        @(negedge clk); init = 1'b0; cfg_we = 1'b0;
        check("R10 init clears req", req, 8'h00);
        check("R10 init beats write", cfg_rd, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule